// File: doc/BRIEF.md
# Masked Event Interrupt Aggregator

This block gathers ninety-six single-cycle hardware event inputs into sticky status bits and merges them onto three level-sensitive interrupt request lines. Every status bit stays set until software acknowledges it by writing a one to its position. Each interrupt line has its own full set of enable masks covering all ninety-six events. A line is asserted while at least one event that is enabled for it is pending.

For each line, a read-only register gives the number of the lowest-numbered event that is both pending and enabled, together with a valid flag. An interrupt handler can read that one word to find its source and does not need to scan the status words bit by bit. The register interface is a plain 32-bit word bus. A write commits on the clock edge. A read returns data combinationally from registered state.

Top module: `evtagg_top`

## Requirements
- R1: After reset every status bit and every mask bit is 0, all three interrupt outputs are low, and every register reads 0.
- R2: A high level on event input n (n = 32*w + j) sets bit j of the status word at byte offset 4*w (w = 0..2). The bit stays 1 until it is cleared by software.
- R3: A write to a status word clears each bit where the write data holds a 1. Bits where the write data holds a 0 are left unchanged.
- R4: If an event input is high in the same cycle as a write that clears its own status bit, the bit remains 1.
- R5: The mask word for line g (g = 0..2) and status word w is a read/write register at byte offset 0x10*(g+1) + 4*w. It returns exactly the value last written to it.
- R6: irqOut[g] is high exactly when some event is both pending and enabled in mask set g. It falls in the first cycle after the contributing bits are cleared or disabled.
- R7: The three lines are independent. Enabling an event in one mask set has no effect on the other lines.
- R8: The pending-index word for line g at byte offset 0x40 + 4*g reads bit 7 = valid and bits 6:0 = the lowest event number that is pending and enabled for line g. All other bits are 0, and the whole word is 0 when nothing is pending for that line.
- R9: A read of any other offset, unaligned offsets included, returns 0. Writes to those offsets and to the pending-index words change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | 96 | Event inputs, one bit per event |
| busAddr | input | 8 | Register byte offset |
| busWrEn | input | 1 | Write strobe, committed on the clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| irqOut | output | 3 | Interrupt request lines, index 0 is the highest priority |

## Verification
The hardest case to reach is an event arriving in exactly the cycle in which software is acknowledging the same bit. The bench produces it by driving the event bit and the clearing write on the same falling edge. It then reads the status word back to confirm that the bit survived. A second hard case is showing that the pending index moves to the next enabled event once the lowest one is cleared. To set this up, the bench makes one line hold two pending enabled events in different status words, clears the lower one, and then clears the higher one.

// File: rtl/evtagg_pkg.sv
`timescale 1ns/1ps
package evtagg_pkg;
  localparam int EVT_WORDS = 3;
  localparam int WORD_W    = 32;
  localparam int IRQ_LINES = 3;
  localparam int ADDR_W    = 8;
  localparam int WSEL_W    = $clog2(EVT_WORDS);
  localparam int GSEL_W    = $clog2(IRQ_LINES);

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_MASK   = 2'd2,
    RD_PEND   = 2'd3
  } rdsel_e;

  // Strobes from decode control to the datapath
  typedef struct packed {
    logic [EVT_WORDS-1:0]           clrStatus;
    logic [IRQ_LINES*EVT_WORDS-1:0] wrMask;
    rdsel_e                         rdSel;
    logic [GSEL_W-1:0]              rdGroup;
    logic [WSEL_W-1:0]              rdWord;
  } strobe_t;
endpackage

// File: rtl/evtagg_ctrl.sv
`timescale 1ns/1ps
module evtagg_ctrl
  import evtagg_pkg::*;
#(
  parameter int NW = EVT_WORDS,
  parameter int NL = IRQ_LINES,
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] busAddr,
  input  logic          busWrEn,
  output strobe_t       strb
);
  localparam int REG_W    = AW - 4;
  localparam int PEND_REG = NL + 1;

  logic [REG_W-1:0] region;
  logic [1:0]       sub;
  logic             aligned;

  assign region  = busAddr[AW-1:4];
  assign sub     = busAddr[3:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    if (aligned) begin
      if (int'(region) == 0) begin
        if (int'(sub) < NW) begin
          strb.rdSel  = RD_STATUS;
          strb.rdWord = WSEL_W'(sub);
          strb.clrStatus[sub] = busWrEn;
        end
      end else if (int'(region) <= NL) begin
        if (int'(sub) < NW) begin
          strb.rdSel   = RD_MASK;
          strb.rdWord  = WSEL_W'(sub);
          strb.rdGroup = GSEL_W'(int'(region) - 1);
          strb.wrMask[(int'(region) - 1) * NW + int'(sub)] = busWrEn;
        end
      end else if (int'(region) == PEND_REG) begin
        if (int'(sub) < NL) begin
          strb.rdSel   = RD_PEND;
          strb.rdGroup = GSEL_W'(sub);
        end
      end
    end
  end
endmodule

// File: rtl/evtagg_datapath.sv
`timescale 1ns/1ps
module evtagg_datapath
  import evtagg_pkg::*;
#(
  parameter int NW = EVT_WORDS,
  parameter int NL = IRQ_LINES,
  parameter int WW = WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [WW-1:0]     busWrData,
  input  logic [NW*WW-1:0]  evtIn,
  output logic [WW-1:0]     busRdData,
  output logic [NL-1:0]     irqOut,
  output logic [NW*WW-1:0]  statusVec,
  output logic [NL*NW*WW-1:0] maskFlat
);
  localparam int EVT_N = NW * WW;
  localparam int IDX_W = $clog2(EVT_N);

  logic [EVT_N-1:0] statusQ;
  logic [EVT_N-1:0] clrVec;
  logic [EVT_N-1:0] maskQ   [NL];
  logic [EVT_N-1:0] masked  [NL];
  logic [IDX_W:0]   pendIdx [NL];

  function automatic logic [IDX_W:0] lowestSet(input logic [EVT_N-1:0] v);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = EVT_N - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, IDX_W'(i)};
    end
    return r;
  endfunction

  // Clear vector from acknowledging writes
  for (genvar w = 0; w < NW; w++) begin : g_clr
    assign clrVec[w*WW +: WW] = strb.clrStatus[w] ? busWrData : '0;
  end

  // Sticky status: a new event overrides a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clrVec) | evtIn;
  end

  for (genvar g = 0; g < NL; g++) begin : g_line
    for (genvar w = 0; w < NW; w++) begin : g_word
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                    maskQ[g][w*WW +: WW] <= '0;
        else if (strb.wrMask[g*NW+w]) maskQ[g][w*WW +: WW] <= busWrData;
      end
    end
    assign masked[g]  = statusQ & maskQ[g];
    assign irqOut[g]  = |masked[g];
    assign pendIdx[g] = lowestSet(masked[g]);
    assign maskFlat[g*EVT_N +: EVT_N] = maskQ[g];
  end

  assign statusVec = statusQ;

  always_comb begin
    busRdData = '0;
    unique case (strb.rdSel)
      RD_STATUS: busRdData = statusQ[int'(strb.rdWord)*WW +: WW];
      RD_MASK:   busRdData = maskQ[strb.rdGroup][int'(strb.rdWord)*WW +: WW];
      RD_PEND:   busRdData = WW'(pendIdx[strb.rdGroup]);
      default:   busRdData = '0;
    endcase
  end
endmodule

// File: rtl/evtagg_top.sv
`timescale 1ns/1ps
module evtagg_top
  import evtagg_pkg::*;
#(
  parameter int NW = EVT_WORDS,
  parameter int NL = IRQ_LINES,
  parameter int WW = WORD_W,
  parameter int AW = ADDR_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NW*WW-1:0] evtIn,
  input  logic [AW-1:0]   busAddr,
  input  logic            busWrEn,
  input  logic [WW-1:0]   busWrData,
  output logic [WW-1:0]   busRdData,
  output logic [NL-1:0]   irqOut
);
  strobe_t              strb;
  logic [NW*WW-1:0]     statusVec;
  logic [NL*NW*WW-1:0]  maskFlat;

  evtagg_ctrl #(.NW(NW), .NL(NL), .AW(AW)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strb    (strb)
  );

  evtagg_datapath #(.NW(NW), .NL(NL), .WW(WW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busWrData (busWrData),
    .evtIn     (evtIn),
    .busRdData (busRdData),
    .irqOut    (irqOut),
    .statusVec (statusVec),
    .maskFlat  (maskFlat)
  );
endmodule

// File: rtl/evtagg_chk.sv
`timescale 1ns/1ps
module evtagg_chk #(
  parameter int NW = 3,
  parameter int NL = 3,
  parameter int WW = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic [NW*WW-1:0]    evtIn,
  input logic                busWrEn,
  input logic [NL-1:0]       irqOut,
  input logic [NW*WW-1:0]    statusVec,
  input logic [NL*NW*WW-1:0] maskFlat
);
  localparam int EVT_N = NW * WW;

  // R2 and R4: an event bit is always set one edge later
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((statusVec & $past(evtIn)) == $past(evtIn)));

  // R2: no status bit rises without its event
  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((statusVec & ~$past(statusVec) & ~$past(evtIn)) == '0));

  // R3: status only falls after a bus write
  a_r3_clear_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> ((~statusVec & $past(statusVec)) == '0));

  // R5: masks hold without a write
  a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(maskFlat));

  // R6: nothing pending means no request
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (statusVec == '0) |-> (irqOut == '0));

  for (genvar g = 0; g < NL; g++) begin : g_line
    // R7: a line with an empty mask set stays low
    a_r7_empty_mask_quiet: assert property (@(posedge clk) disable iff (!rstN)
      (maskFlat[g*EVT_N +: EVT_N] == '0) |-> !irqOut[g]);
  end
endmodule

bind evtagg_top evtagg_chk #(.NW(NW), .NL(NL), .WW(WW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .evtIn     (evtIn),
  .busWrEn   (busWrEn),
  .irqOut    (irqOut),
  .statusVec (statusVec),
  .maskFlat  (maskFlat)
);

// File: tb/tb_evtagg_top.sv
`timescale 1ns/1ps
module tb_evtagg_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [95:0] evtIn = '0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [2:0]  irqOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evtagg_top dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    busAddr = a;
    #1;
    chk(req, busRdData, exp);
  endtask

  task automatic pulse(input logic [95:0] v);
    @(negedge clk);
    evtIn = v;
    @(negedge clk);
    evtIn = '0;
  endtask

  task automatic irqChk(input string req, input logic [2:0] exp);
    @(negedge clk);
    #1;
    chk(req, {29'd0, irqOut}, {29'd0, exp});
  endtask

  task automatic t_reset();
    rdChk("R1 status0", 8'h00, 0);
    rdChk("R1 status2", 8'h08, 0);
    rdChk("R1 mask g0w0", 8'h10, 0);
    rdChk("R1 mask g1w1", 8'h24, 0);
    rdChk("R1 mask g2w2", 8'h38, 0);
    rdChk("R1 pend0", 8'h40, 0);
    rdChk("R1 pend2", 8'h48, 0);
    irqChk("R1 irq", 3'b000);
  endtask

  task automatic t_sticky();
    logic [95:0] v = '0;
    v[37] = 1'b1; v[0] = 1'b1;
    pulse(v);
    rdChk("R2 word1", 8'h04, 32'h20);
    rdChk("R2 word0", 8'h00, 32'h1);
    repeat (3) @(negedge clk);
    rdChk("R2 word1 held", 8'h04, 32'h20);
    irqChk("R6 masked off", 3'b000);
  endtask

  task automatic t_w1c();
    wr(8'h00, 32'h1);
    rdChk("R3 cleared", 8'h00, 0);
    wr(8'h04, 32'h0);
    rdChk("R3 zero write keeps", 8'h04, 32'h20);
    wr(8'h04, 32'h20);
    rdChk("R3 cleared word1", 8'h04, 0);
  endtask

  task automatic t_setWins();
    @(negedge clk);
    evtIn = '0; evtIn[7] = 1'b1;
    busAddr = 8'h00; busWrData = 32'h80; busWrEn = 1'b1;
    @(negedge clk);
    evtIn = '0; busWrEn = 1'b0; busWrData = '0;
    rdChk("R4 set wins", 8'h00, 32'h80);
    wr(8'h00, 32'h80);
    rdChk("R4 later clear", 8'h00, 0);
  endtask

  task automatic t_maskRw();
    for (int g = 0; g < 3; g++)
      for (int w = 0; w < 3; w++)
        wr(8'(16*(g+1) + 4*w), 32'hC0DE0000 | (g << 8) | w);
    for (int g = 0; g < 3; g++)
      for (int w = 0; w < 3; w++)
        rdChk("R5 mask readback", 8'(16*(g+1) + 4*w), 32'hC0DE0000 | (g << 8) | w);
    for (int g = 0; g < 3; g++)
      for (int w = 0; w < 3; w++)
        wr(8'(16*(g+1) + 4*w), 0);
    rdChk("R5 mask zeroed", 8'h24, 0);
  endtask

  task automatic t_irq();
    logic [95:0] v;
    wr(8'h10, 32'h80);
    v = '0; v[7] = 1'b1;
    pulse(v);
    irqChk("R7 only line0", 3'b001);
    rdChk("R8 pend0", 8'h40, 32'h87);
    rdChk("R8 pend1 empty", 8'h44, 0);
    wr(8'h38, 32'h40);
    v = '0; v[70] = 1'b1;
    pulse(v);
    irqChk("R6 line0 and line2", 3'b101);
    rdChk("R8 pend2", 8'h48, 32'hC6);
    wr(8'h18, 32'h40);
    rdChk("R8 lowest wins", 8'h40, 32'h87);
    wr(8'h00, 32'h80);
    rdChk("R8 next event", 8'h40, 32'hC6);
    irqChk("R6 still pending", 3'b101);
    wr(8'h38, 32'h0);
    irqChk("R6 mask drop", 3'b001);
    wr(8'h08, 32'h40);
    irqChk("R6 clear drop", 3'b000);
    rdChk("R8 empty", 8'h40, 0);
  endtask

  task automatic t_unmapped();
    wr(8'h0C, 32'hFFFFFFFF);
    wr(8'h1C, 32'hFFFFFFFF);
    wr(8'h40, 32'hFFFFFFFF);
    wr(8'h50, 32'hFFFFFFFF);
    wr(8'h11, 32'hFFFFFFFF);
    wr(8'h02, 32'hFFFFFFFF);
    rdChk("R9 read 0C", 8'h0C, 0);
    rdChk("R9 read 1C", 8'h1C, 0);
    rdChk("R9 read 50", 8'h50, 0);
    rdChk("R9 read 11", 8'h11, 0);
    rdChk("R9 read FC", 8'hFC, 0);
    rdChk("R9 mask g0w0 kept", 8'h10, 32'h80);
    rdChk("R9 mask g0w1 kept", 8'h14, 0);
    rdChk("R9 mask g0w2 kept", 8'h18, 32'h40);
    rdChk("R9 status kept", 8'h00, 0);
    rdChk("R9 pend0 kept", 8'h40, 0);
    irqChk("R9 irq quiet", 3'b000);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_sticky();
    t_w1c();
    t_setWins();
    t_maskRw();
    t_irq();
    t_unmapped();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule